// File: doc/BRIEF.md
# Paged Multi-Bank Video Memory Router

The router sits between graphics-engine fetch and store requests and nine physical video-memory banks. Each request names a target space (one of two engines' background or object space, a secondary-processor window, or an automatic background/object split decided by the address) and a 32-bit byte address. The address picks a page, and the page picks an entry in that space's page table. The entry is a nine-bit set of banks.

A write is sent to every bank in the set at once. A read enables every bank in the set. One cycle later it returns the bitwise OR of their data, so banks that overlap on one page merge their contents. Each bank sees the address wrapped to its own size. Every space may only reach a fixed subset of the banks, and any other bank named in an entry is ignored.

Page-table entries are loaded through a plain register port. An entry written in one cycle governs accesses from the next cycle on.

The request side is a valid/ready stream. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and its payload until then. Reads produce a response stream (`rsp_valid`/`rsp_ready`) and writes produce none. While a response is waiting and `rsp_ready` is low, `req_ready` drops and no bank is touched. The banks are expected to return read data one cycle after an enabled read and to keep it until their next enabled access.

Top module: `vram_router`

## Requirements
- R1: After reset every page-table entry is empty, `rsp_valid` is low, and no bank is enabled until a mapping is written.
- R2: The page index is the address shifted right by 14, masked to the table depth of the space: 32 entries for engine-A background (code 0), 16 for engine-A object (code 1), and 8 each for engine-B background (code 2) and engine-B object (code 3). Higher pages wrap. The secondary window (code 4) has 2 entries chosen by address bit 17.
- R3: Each space may only use a fixed set of banks: code 0 uses banks 0–6; code 1 uses 0, 1, 4, 5 and 6; code 2 uses 2, 7 and 8; code 3 uses 3 and 8; code 4 uses 2 and 3. Other mask bits are ignored for reads and writes.
- R4: An accepted read raises `bank_en` bit n (bank n) for every permitted bank in the entry, with `bank_we` low, in the cycle of acceptance. In the next cycle `rsp_valid` is high and `rsp_data` is the OR of those banks' `bank_rdata` slices. An empty set reads as zero.
- R5: An accepted write raises `bank_we` and the same `bank_en` set in the acceptance cycle, with `bank_wdata` equal to `req_wdata`, and produces no response.
- R6: `bank_addr` holds one 17-bit field per bank, bank n at bits [17n+16:17n]. Each field is the address wrapped to that bank's size, with the upper bits zero: 17 bits for banks 0–3, 16 for bank 4, 15 for bank 7, and 14 for banks 5, 6 and 8.
- R7: Request codes 5 and 6 split by address bits [31:21]. Code 5 goes to code 0 when those bits equal 0x030 and to code 2 otherwise. Code 6 goes to code 1 when they equal 0x032 and to code 3 otherwise. Code 7 selects no bank, and a read with it returns zero.
- R8: A page-table write stores `pt_mask` at `pt_index` wrapped to the table depth of `pt_region` (codes 0–4). A write to codes 5–7 changes nothing. The new entry applies from the next cycle.
- R9: `req_ready` is low exactly when `rsp_valid` is high and `rsp_ready` is low. `rsp_valid` then stays high, and `bank_en` and `bank_we` stay low while no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_sel | input | 3 | Target space code (0–7) |
| req_addr | input | 32 | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | DATA_W | OR-merged read data |
| pt_we | input | 1 | Page-table write strobe |
| pt_region | input | 3 | Table selected for the write (0–4) |
| pt_index | input | 5 | Entry index, wrapped to the table depth |
| pt_mask | input | 9 | Bank set for the entry |
| bank_en | output | 9 | Per-bank access enable |
| bank_we | output | 1 | Write strobe shared by all banks |
| bank_addr | output | 153 | Per-bank wrapped offset, 17 bits per bank |
| bank_wdata | output | DATA_W | Write data shared by all banks |
| bank_rdata | input | 9*DATA_W | Per-bank read data, one cycle after an enabled read |

## Verification
The hardest case to reach is a merged read whose banks hold different contents, taken while the response path is stalled. The OR only shows a fault when the banks differ. The stimulus gives each bank an address-dependent background value and writes distinct words through single-bank pages. It then reads the same offsets through a page that overlaps several banks, and holds `rsp_ready` low across back-to-back reads. A long random phase mixes table writes, all eight request codes, wrapping page numbers and random back-pressure, while the requester holds any request that was not accepted.

// File: rtl/vram_rt_pkg.sv
`timescale 1ns/1ps
package vram_rt_pkg;
  localparam int NBANK     = 9;
  localparam int BANK_AW   = 17;
  localparam int NREGION   = 5;
  localparam int TBL_TOTAL = 66;
  localparam int TBL_AW    = $clog2(TBL_TOTAL);
  localparam int IDX_W     = 5;

  localparam logic [2:0] RG_ABG  = 3'd0;
  localparam logic [2:0] RG_AOBJ = 3'd1;
  localparam logic [2:0] RG_BBG  = 3'd2;
  localparam logic [2:0] RG_BOBJ = 3'd3;
  localparam logic [2:0] RG_SUB  = 3'd4;

  typedef enum logic [2:0] {
    SEL_ABG = 3'd0, SEL_AOBJ = 3'd1, SEL_BBG = 3'd2, SEL_BOBJ = 3'd3,
    SEL_SUB = 3'd4, SEL_AUTO_BG = 3'd5, SEL_AUTO_OBJ = 3'd6, SEL_NONE = 3'd7
  } sel_e;

  // address bits kept by each bank
  function automatic int bank_aw(input int b);
    if (b < 4)       return 17;
    else if (b == 4) return 16;
    else if (b == 7) return 15;
    else             return 14;
  endfunction

  // banks a region may reach
  function automatic logic [NBANK-1:0] region_perm(input logic [2:0] r);
    case (r)
      RG_ABG:  return 9'h07F;
      RG_AOBJ: return 9'h073;
      RG_BBG:  return 9'h184;
      RG_BOBJ: return 9'h108;
      RG_SUB:  return 9'h00C;
      default: return '0;
    endcase
  endfunction

  function automatic int tbl_depth(input logic [2:0] r);
    case (r)
      RG_ABG:  return 32;
      RG_AOBJ: return 16;
      RG_SUB:  return 2;
      default: return 8;
    endcase
  endfunction

  function automatic int tbl_base(input logic [2:0] r);
    case (r)
      RG_ABG:  return 0;
      RG_AOBJ: return 32;
      RG_BBG:  return 48;
      RG_BOBJ: return 56;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/vram_rt_decode.sv
`timescale 1ns/1ps
module vram_rt_decode
  import vram_rt_pkg::*;
#(
  parameter int          PAGE_SHIFT   = 14,
  parameter int          SUB_PAGE_BIT = 17,
  parameter logic [10:0] ABG_BASE     = 11'h030,
  parameter logic [10:0] AOBJ_BASE    = 11'h032
) (
  input  logic [2:0]        sel,
  input  logic [31:0]       addr,
  output logic [2:0]        region,
  output logic              hit,
  output logic [TBL_AW-1:0] slot
);
  logic [31:0] page;
  logic [31:0] wrapped;

  always_comb begin
    hit    = 1'b1;
    region = RG_ABG;
    case (sel_e'(sel))
      SEL_ABG:      region = RG_ABG;
      SEL_AOBJ:     region = RG_AOBJ;
      SEL_BBG:      region = RG_BBG;
      SEL_BOBJ:     region = RG_BOBJ;
      SEL_SUB:      region = RG_SUB;
      // R7: automatic split on the upper address bits
      SEL_AUTO_BG:  region = (addr[31:21] == ABG_BASE)  ? RG_ABG  : RG_BBG;
      SEL_AUTO_OBJ: region = (addr[31:21] == AOBJ_BASE) ? RG_AOBJ : RG_BOBJ;
      default:      hit = 1'b0;
    endcase
  end

  // R2: page number wrapped to the table of the region
  always_comb begin
    if (region == RG_SUB) page = {31'd0, addr[SUB_PAGE_BIT]};
    else                  page = addr >> PAGE_SHIFT;
    wrapped = page & (32'(tbl_depth(region)) - 32'd1);
    slot    = TBL_AW'(32'(tbl_base(region)) + wrapped);
  end
endmodule

// File: rtl/vram_rt_table.sv
`timescale 1ns/1ps
module vram_rt_table
  import vram_rt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_region,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [NBANK-1:0]  wr_mask,
  input  logic [TBL_AW-1:0] rd_slot,
  output logic [NBANK-1:0]  rd_mask
);
  logic [NBANK-1:0]  ent [TBL_TOTAL];
  logic [TBL_AW-1:0] wr_slot;
  logic              wr_ok;

  // R8: index wraps to the depth of the addressed table
  always_comb begin
    wr_ok   = wr_en && (wr_region < 3'(NREGION));
    wr_slot = TBL_AW'(32'(tbl_base(wr_region)) +
                      (32'(wr_index) & (32'(tbl_depth(wr_region)) - 32'd1)));
  end

  // R3: forbidden banks are dropped when the entry is stored
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_TOTAL; i++) ent[i] <= '0;
    end else if (wr_ok) begin
      ent[wr_slot] <= wr_mask & region_perm(wr_region);
    end
  end

  assign rd_mask = ent[rd_slot];
endmodule

// File: rtl/vram_rt_fanout.sv
`timescale 1ns/1ps
module vram_rt_fanout
  import vram_rt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     go,
  input  logic                     we,
  input  logic [NBANK-1:0]         mask,
  input  logic [BANK_AW-1:0]       addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [NBANK-1:0]         bank_en,
  output logic                     bank_we,
  output logic [NBANK*BANK_AW-1:0] bank_addr,
  output logic [DATA_W-1:0]        bank_wdata
);
  assign bank_we    = go & we;
  assign bank_wdata = wdata;

  // R6: each bank sees the offset wrapped to its own size
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int AWB = bank_aw(b);
    assign bank_en[b] = go & mask[b];
    if (AWB < BANK_AW) begin : g_pad
      assign bank_addr[b*BANK_AW +: BANK_AW] = {{(BANK_AW-AWB){1'b0}}, addr[AWB-1:0]};
    end else begin : g_full
      assign bank_addr[b*BANK_AW +: BANK_AW] = addr;
    end
  end
endmodule

// File: rtl/vram_rt_merge.sv
`timescale 1ns/1ps
module vram_rt_merge
  import vram_rt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_go,
  input  logic [NBANK-1:0]        rd_mask,
  input  logic [NBANK*DATA_W-1:0] bank_rdata,
  input  logic                    rsp_ready,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_data
);
  logic [NBANK-1:0]  mask_q;
  logic [DATA_W-1:0] merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      mask_q    <= '0;
    end else if (rd_go) begin
      rsp_valid <= 1'b1;
      mask_q    <= rd_mask;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R4: OR of every bank that took part in the read
  always_comb begin
    merged = '0;
    for (int b = 0; b < NBANK; b++)
      if (mask_q[b]) merged = merged | bank_rdata[b*DATA_W +: DATA_W];
    rsp_data = rsp_valid ? merged : '0;
  end

  // R4
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rsp_valid);
  // R4
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(rd_go));
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);
endmodule

// File: rtl/vram_router.sv
`timescale 1ns/1ps
module vram_router
  import vram_rt_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter int          PAGE_SHIFT   = 14,
  parameter int          SUB_PAGE_BIT = 17,
  parameter logic [10:0] ABG_BASE     = 11'h030,
  parameter logic [10:0] AOBJ_BASE    = 11'h032
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2:0]               req_sel,
  input  logic [31:0]              req_addr,
  input  logic                     req_we,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DATA_W-1:0]        rsp_data,
  input  logic                     pt_we,
  input  logic [2:0]               pt_region,
  input  logic [IDX_W-1:0]         pt_index,
  input  logic [NBANK-1:0]         pt_mask,
  output logic [NBANK-1:0]         bank_en,
  output logic                     bank_we,
  output logic [NBANK*BANK_AW-1:0] bank_addr,
  output logic [DATA_W-1:0]        bank_wdata,
  input  logic [NBANK*DATA_W-1:0]  bank_rdata
);
  logic [2:0]        dec_region;
  logic              dec_hit;
  logic [TBL_AW-1:0] dec_slot;
  logic [NBANK-1:0]  tbl_mask;
  logic [NBANK-1:0]  eff_mask;
  logic              accepted;

  // R9: stall only while a response waits
  assign req_ready = !(rsp_valid && !rsp_ready);
  assign accepted  = req_valid && req_ready;
  assign eff_mask  = dec_hit ? tbl_mask : '0;

  vram_rt_decode #(
    .PAGE_SHIFT(PAGE_SHIFT), .SUB_PAGE_BIT(SUB_PAGE_BIT),
    .ABG_BASE(ABG_BASE), .AOBJ_BASE(AOBJ_BASE)
  ) u_decode (
    .sel(req_sel), .addr(req_addr),
    .region(dec_region), .hit(dec_hit), .slot(dec_slot)
  );

  vram_rt_table u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pt_we), .wr_region(pt_region), .wr_index(pt_index), .wr_mask(pt_mask),
    .rd_slot(dec_slot), .rd_mask(tbl_mask)
  );

  vram_rt_fanout #(.DATA_W(DATA_W)) u_fanout (
    .go(accepted), .we(req_we), .mask(eff_mask),
    .addr(req_addr[BANK_AW-1:0]), .wdata(req_wdata),
    .bank_en(bank_en), .bank_we(bank_we),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata)
  );

  vram_rt_merge #(.DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .rd_go(accepted && !req_we), .rd_mask(eff_mask),
    .bank_rdata(bank_rdata), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // R3
  perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en & ~region_perm(dec_region)) == '0);
  // R9
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (bank_en == '0 && !bank_we));
  // R7
  no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sel == 3'd7) |-> (bank_en == '0));
  // R5
  write_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> (req_valid && req_we));
endmodule

// File: tb/test_vram_router.sv
`timescale 1ns/1ps
module test_vram_router;
  localparam int DW = 32;
  localparam int NB = 9;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           req_valid = 0, req_we = 0, rsp_ready = 1, pt_we = 0;
  logic [2:0]     req_sel = 0, pt_region = 0;
  logic [31:0]    req_addr = 0;
  logic [DW-1:0]  req_wdata = 0;
  logic [4:0]     pt_index = 0;
  logic [8:0]     pt_mask = 0;
  logic           req_ready, rsp_valid, bank_we;
  logic [DW-1:0]  rsp_data, bank_wdata;
  logic [NB-1:0]  bank_en;
  logic [NB*AW-1:0] bank_addr;
  logic [NB*DW-1:0] brd = '0;

  vram_router #(.DATA_W(DW)) i_vram_router (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pt_we(pt_we), .pt_region(pt_region), .pt_index(pt_index), .pt_mask(pt_mask),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_rdata(brd)
  );

  // bank environment: sparse storage with an address-dependent background
  logic [31:0] bmem [int];
  function automatic logic [31:0] bval(int b, int a);
    int k = b * (1 << 20) + a;
    if (bmem.exists(k)) return bmem[k];
    return (32'(b + 1) << 24) ^ 32'(a) ^ 32'h00A50000;
  endfunction
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (bank_en[b]) begin
        if (bank_we) bmem[b * (1 << 20) + int'(bank_addr[b*AW +: AW])] = bank_wdata;
        else brd[b*DW +: DW] <= bval(b, int'(bank_addr[b*AW +: AW]));
      end
  end

  // reference model
  logic [8:0]  mt [5][32];
  bit          e_rv = 0;
  logic [31:0] e_rd = 0;
  bit          g_rdy = 1;
  int          n_chk = 0, n_fail = 0;
  string       ph = "R1";

  function automatic logic [8:0] perm_m(int r);
    logic [8:0] m = '0;
    case (r)
      0: for (int b = 0; b <= 6; b++) m[b] = 1'b1;
      1: begin m[0] = 1; m[1] = 1; m[4] = 1; m[5] = 1; m[6] = 1; end
      2: begin m[2] = 1; m[7] = 1; m[8] = 1; end
      3: begin m[3] = 1; m[8] = 1; end
      4: begin m[2] = 1; m[3] = 1; end
      default: m = '0;
    endcase
    return m;
  endfunction
  function automatic int depth_m(int r);
    case (r) 0: return 32; 1: return 16; 4: return 2; default: return 8; endcase
  endfunction
  function automatic int resolve(logic [2:0] s, logic [31:0] a);
    if (s <= 3'd4) return int'(s);
    if (s == 3'd5) return (a[31:21] == 11'h030) ? 0 : 2;
    if (s == 3'd6) return (a[31:21] == 11'h032) ? 1 : 3;
    return -1;
  endfunction
  function automatic int page_m(int r, logic [31:0] a);
    if (r == 4) return int'(a[17]);
    return int'((a / 32'd16384) % 32'(depth_m(r)));
  endfunction
  function automatic int awm(int b);
    if (b < 4) return 17;
    if (b == 4) return 16;
    if (b == 7) return 15;
    return 14;
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", ph, what, act, exp);
    end
  endtask

  // one clock: compare everything, then advance the model
  task automatic cyc();
    int r;
    logic [8:0] m;
    bit rdy, acc;
    logic [31:0] d, off;
    #1;
    rdy = !(e_rv && !rsp_ready);
    acc = req_valid && rdy;
    r = resolve(req_sel, req_addr);
    m = '0;
    if (acc && r >= 0) m = mt[r][page_m(r, req_addr)] & perm_m(r);
    chk("req_ready", 64'(req_ready), 64'(rdy));
    chk("bank_en", 64'(bank_en), 64'(m));
    chk("bank_we", 64'(bank_we), 64'(acc && req_we));
    chk("rsp_valid", 64'(rsp_valid), 64'(e_rv));
    if (e_rv) chk("rsp_data", 64'(rsp_data), 64'(e_rd));
    d = '0;
    for (int b = 0; b < NB; b++)
      if (m[b]) begin
        off = req_addr & ((32'd1 << awm(b)) - 32'd1);
        chk($sformatf("bank_addr[%0d]", b), 64'(bank_addr[b*AW +: AW]), 64'(off));
        if (req_we) chk("bank_wdata", 64'(bank_wdata), 64'(req_wdata));
        d = d | bval(b, int'(off));
      end
    g_rdy = rdy;
    @(posedge clk);
    if (acc && !req_we) begin e_rv = 1; e_rd = d; end
    else if (rsp_ready) e_rv = 0;
    if (pt_we && pt_region < 3'd5)
      mt[pt_region][int'(pt_index) % depth_m(int'(pt_region))] = pt_mask;
    @(negedge clk);
  endtask

  task automatic access(logic [2:0] s, logic [31:0] a, bit w, logic [31:0] dat);
    req_valid = 1; req_sel = s; req_addr = a; req_we = w; req_wdata = dat;
    cyc();
    req_valid = 0; req_we = 0;
  endtask
  task automatic map(int rg, int idx, logic [8:0] mk);
    pt_we = 1; pt_region = 3'(rg); pt_index = 5'(idx); pt_mask = mk;
    cyc();
    pt_we = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 5; r++) for (int i = 0; i < 32; i++) mt[r][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    ph = "R1";
    cyc(); cyc();
    for (int s = 0; s < 8; s++) begin access(3'(s), 32'h0600_0000 + 32'(s) * 32'h4000, 0, 0); cyc(); end

    ph = "R8";
    map(0, 0, 9'h001);
    access(3'd0, 32'h0600_0010, 0, 0); cyc();
    map(1, 17, 9'h002);                        // wraps to entry 1
    access(3'd1, 32'h0640_4020, 0, 0); cyc();
    map(5, 0, 9'h1FF);                         // no table: nothing changes
    map(7, 3, 9'h1FF);
    access(3'd0, 32'h0600_0010, 0, 0); cyc();
    access(3'd3, 32'h0660_0000, 0, 0); cyc();
    pt_we = 1; pt_region = 0; pt_index = 4; pt_mask = 9'h010;
    access(3'd0, 32'h0601_0000, 0, 0);         // same cycle: old (empty) entry
    pt_we = 0;
    access(3'd0, 32'h0601_0000, 0, 0); cyc();  // next access: new entry

    ph = "R3";
    for (int r = 0; r < 5; r++) map(r, 0, 9'h1FF);
    for (int s = 0; s < 5; s++) begin access(3'(s), 32'h0600_0000, 0, 0); cyc(); end
    map(2, 1, 9'h07B);                         // only forbidden banks for code 2
    access(3'd2, 32'h0620_4000, 1, 32'hDEAD_0001); cyc();
    access(3'd2, 32'h0620_4000, 0, 0); cyc();

    ph = "R5";
    map(0, 8, 9'h001); map(0, 9, 9'h002); map(0, 10, 9'h010);
    access(3'd0, 32'h0602_0040, 1, 32'h1111_0000);
    access(3'd0, 32'h0602_4040, 1, 32'h0000_2222);
    access(3'd0, 32'h0602_8040, 1, 32'h0330_0000);
    map(0, 11, 9'h013);
    access(3'd0, 32'h0602_C040, 1, 32'h5A5A_5A5A);

    ph = "R4";
    map(0, 12, 9'h013);
    access(3'd0, 32'h0603_0040, 0, 0); cyc();
    map(0, 13, 9'h000);
    access(3'd0, 32'h0603_4040, 0, 0); cyc();
    map(2, 2, 9'h184);
    access(3'd2, 32'h0620_8123, 0, 0); cyc();

    ph = "R6";
    map(0, 14, 9'h07F);
    access(3'd0, 32'h0603_BFFF, 1, 32'hCAFE_F00D);
    access(3'd0, 32'h0603_BFFF, 0, 0); cyc();
    map(3, 7, 9'h108);
    access(3'd3, 32'hFFFF_FFFF, 0, 0); cyc();

    ph = "R2";
    map(0, 3, 9'h004);
    access(3'd0, 32'h0608_C000, 0, 0); cyc();  // page 35 -> entry 3
    map(2, 1, 9'h080);
    access(3'd2, 32'h0622_4000, 0, 0); cyc();  // page 9 -> entry 1
    map(4, 1, 9'h008); map(4, 0, 9'h004);
    access(3'd4, 32'h0602_0000, 0, 0); cyc();
    access(3'd4, 32'h0601_C000, 0, 0); cyc();
    access(3'd4, 32'h0606_0000, 0, 0); cyc();

    ph = "R7";
    map(0, 0, 9'h020); map(2, 0, 9'h100); map(1, 0, 9'h040); map(3, 0, 9'h008);
    access(3'd5, 32'h0600_0000, 0, 0); cyc();
    access(3'd5, 32'h0620_0000, 0, 0); cyc();
    access(3'd6, 32'h0640_0000, 0, 0); cyc();
    access(3'd6, 32'h0660_0000, 0, 0); cyc();
    access(3'd6, 32'h0600_0000, 0, 0); cyc();
    access(3'd7, 32'h0600_0000, 0, 0); cyc();

    ph = "R9";
    rsp_ready = 0;
    req_valid = 1; req_sel = 0; req_addr = 32'h0600_0000; req_we = 0;
    cyc(); cyc(); cyc(); cyc();
    rsp_ready = 1;
    cyc(); cyc();
    req_valid = 0;
    cyc(); cyc();

    ph = "R4";
    for (int it = 0; it < 6000; it++) begin
      if (!(req_valid && !g_rdy)) begin
        req_valid = ($urandom % 10) < 7;
        req_sel   = 3'($urandom % 8);
        req_we    = ($urandom % 3) == 0;
        req_wdata = $urandom;
        case ($urandom % 5)
          0: req_addr = 32'h0600_0000;
          1: req_addr = 32'h0620_0000;
          2: req_addr = 32'h0640_0000;
          3: req_addr = 32'h0660_0000;
          default: req_addr = 32'h0680_0000;
        endcase
        req_addr = req_addr | ($urandom & 32'h001F_FFFF);
      end
      rsp_ready = ($urandom % 10) < 7;
      pt_we     = ($urandom % 6) == 0;
      pt_region = 3'($urandom % 8);
      pt_index  = 5'($urandom);
      pt_mask   = 9'($urandom);
      cyc();
    end
    req_valid = 0; pt_we = 0; rsp_ready = 1;
    cyc(); cyc();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule